// File: doc/BRIEF.md
# Request-Gated Clock Output Stopper

This block sits between a free-running clock source and a group of clock output pairs. Each output carries a true clock, its complement and a tri-state enable. Outputs can be stopped and restarted at any time by two asynchronous active-low request inputs, by an active-low bus-clock stop input, or by a software run bit. Every stop and every restart is aligned to a clean clock boundary, so no output ever shows a shortened pulse.

The output clocks run at half the rate of the block clock `clk`. Static configuration vectors give the rest of the setup. A per-request enable and a per-request mask choose which outputs each request controls. A stoppable bit marks the outputs that follow the bus stop and the software stop; an output with this bit clear runs free. A per-output float bit chooses whether a stopped pair stays driven low or is tri-stated. Request inputs pass through a synchronizer and then a debouncer that samples on the rising edges of the complement clock.

Top module: `clk_req_stopper`

## Requirements
- R1: When reset is released, every output is running: `clk_oe` is 1, and `clk_t`/`clk_c` toggle in step with the free-running phase.
- R2: A request level is accepted only after it reads the same on two consecutive rising edges of the complement clock. A request pulse one `clk` cycle wide has no effect on any output.
- R3: When request r is held high (deasserted) and `req_en[r]` is 1, every output i with `req_mask[r*NUM_OUT+i]` = 1 stops within 12 `clk` cycles. A stopped output has `clk_t` = 0 and `clk_c` = 0.
- R4: When request r returns low (asserted), the outputs it stopped resume within 12 `clk` cycles. They resume in phase with the free-running outputs, and all of them in the same cycle.
- R5: A request whose `req_en` bit is 0 has no effect on any output, whatever its level.
- R6: While `bus_stop_n` is 0, every output whose `stoppable` bit is 1 is stopped, and outputs whose bit is 0 keep running. When `bus_stop_n` returns to 1, the bus-stopped outputs resume within 4 `clk` cycles (two output clock periods).
- R7: While `sw_run` is 0, outputs act exactly as they do while `bus_stop_n` is 0. When `sw_run` returns to 1, they resume.
- R8: A stopped output with `float_on_stop[i]` = 1 has `clk_oe` = 0. A stopped output with `float_on_stop[i]` = 0 has `clk_oe` = 1. A running output always has `clk_oe` = 1.
- R9: No pulse is ever shortened. `clk_t[i]` is high only while the free-running true clock is high, `clk_c[i]` is high only while the free-running complement is high, and the two are never high together.
- R10: The run/stop state of an output changes only at a `clk` edge that ends a low phase of the true clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the output clocks run at half its rate |
| rst | input | 1 | Synchronous active-high reset |
| req_n | input | NUM_REQ | Asynchronous active-low clock requests |
| bus_stop_n | input | 1 | Asynchronous active-low stop for stoppable outputs |
| sw_run | input | 1 | Software run bit: 0 stops stoppable outputs, 1 resumes them |
| req_en | input | NUM_REQ | Per-request enable |
| req_mask | input | NUM_REQ*NUM_OUT | Output i is controlled by request r when bit r*NUM_OUT+i is 1 |
| stoppable | input | NUM_OUT | 1 = output follows the bus stop and the software stop |
| float_on_stop | input | NUM_OUT | 1 = stopped pair is tri-stated, 0 = stopped pair is driven low |
| clk_t | output | NUM_OUT | True clock outputs |
| clk_c | output | NUM_OUT | Complement clock outputs |
| clk_oe | output | NUM_OUT | Output drive enables |

## Verification
The bench sends a request pulse one cycle wide. A debouncer that accepts a single sample would stop the masked outputs on that pulse. A monitor compares every true and complement output with an output that always runs free. Gating applied in the wrong phase would show up there as an output that is high while the reference is low. The bench clears request enables and stoppable bits and checks that those outputs keep running. It also checks that the bus-stopped outputs are running again two output periods after release, and that the tri-state enable follows the float bit only while an output is stopped.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;

    localparam int DEF_NUM_OUT  = 8;
    localparam int DEF_NUM_REQ  = 2;
    localparam int DEF_SYNC_LEN = 2;

    // One gated clock output: true, complement, drive enable
    typedef struct packed {
        logic t;
        logic c;
        logic oe;
    } clk_pair_t;

    // Debouncer state for one request
    typedef struct packed {
        logic sample;   // level seen at the previous complement rising edge
        logic high;     // accepted level: 1 = deasserted (stop)
    } req_state_t;

endpackage

// File: rtl/cdc_sync.sv
module cdc_sync #(
    parameter int   WIDTH   = 1,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0] chain [WIDTH];

    for (genvar w = 0; w < WIDTH; w++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) chain[w] <= {STAGES{RST_VAL}};
            else     chain[w] <= {chain[w][STAGES-2:0], d[w]};
        end
        assign q[w] = chain[w][STAGES-1];
    end
endmodule

// File: rtl/req_filter.sv
module req_filter
    import clk_stop_pkg::*;
#(
    parameter int SYNC_LEN = DEF_SYNC_LEN
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,       // complement clock rising at this edge
    input  logic req_async_n,
    output logic req_high
);
    logic       req_sync;
    req_state_t st;

    cdc_sync #(.WIDTH(1), .STAGES(SYNC_LEN), .RST_VAL(1'b0)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (req_async_n),
        .q   (req_sync)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (tick) begin
            st.sample <= req_sync;
            if (req_sync == st.sample) st.high <= req_sync;
        end
    end

    assign req_high = st.high;

    // R2: the accepted level moves only on complement-clock sample edges
    assert_debounce_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(tick) |-> $stable(st.high));
endmodule

// File: rtl/out_gate.sv
module out_gate
    import clk_stop_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      phase,
    input  logic      stop_req,
    input  logic      float_mode,
    output clk_pair_t pair
);
    logic run_q;

    // Decide only at the edge that ends a low phase
    always_ff @(posedge clk) begin
        if (rst)         run_q <= 1'b1;
        else if (!phase) run_q <= !stop_req;
    end

    assign pair.t  = phase & run_q;
    assign pair.c  = ~phase & run_q;
    assign pair.oe = run_q | ~float_mode;

    // R10: state changes only after a low phase
    assert_change_in_low_R10: assert property (@(posedge clk) disable iff (rst)
        !$stable(run_q) |-> !$past(phase));
    // R9: true and complement never high together
    assert_no_overlap_R9: assert property (@(posedge clk) disable iff (rst)
        !(pair.t && pair.c));
    // R8: a toggling output is always driven
    assert_driven_when_active_R8: assert property (@(posedge clk) disable iff (rst)
        (pair.t || pair.c) |-> pair.oe);
    // R4: after a quiet stop request for three samples the output runs
    assert_resume_R4: assert property (@(posedge clk) disable iff (rst)
        (!stop_req && $past(!stop_req) && $past(!stop_req, 2)) |-> run_q);
endmodule

// File: rtl/clk_req_stopper.sv
module clk_req_stopper
    import clk_stop_pkg::*;
#(
    parameter int NUM_OUT  = DEF_NUM_OUT,
    parameter int NUM_REQ  = DEF_NUM_REQ,
    parameter int SYNC_LEN = DEF_SYNC_LEN
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_REQ-1:0]         req_n,
    input  logic                       bus_stop_n,
    input  logic                       sw_run,
    input  logic [NUM_REQ-1:0]         req_en,
    input  logic [NUM_REQ*NUM_OUT-1:0] req_mask,
    input  logic [NUM_OUT-1:0]         stoppable,
    input  logic [NUM_OUT-1:0]         float_on_stop,
    output logic [NUM_OUT-1:0]         clk_t,
    output logic [NUM_OUT-1:0]         clk_c,
    output logic [NUM_OUT-1:0]         clk_oe
);
    logic               phase;
    logic               bus_stop_sync_n;
    logic               group_stop;
    logic [NUM_REQ-1:0] req_high;
    logic [NUM_OUT-1:0] stop_req;

    // Free-running phase: true clock high while phase is 1
    always_ff @(posedge clk) begin
        if (rst) phase <= 1'b0;
        else     phase <= ~phase;
    end

    cdc_sync #(.WIDTH(1), .STAGES(SYNC_LEN), .RST_VAL(1'b1)) u_bus_sync (
        .clk (clk),
        .rst (rst),
        .d   (bus_stop_n),
        .q   (bus_stop_sync_n)
    );

    assign group_stop = !bus_stop_sync_n || !sw_run;

    for (genvar r = 0; r < NUM_REQ; r++) begin : g_req
        req_filter #(.SYNC_LEN(SYNC_LEN)) u_filter (
            .clk         (clk),
            .rst         (rst),
            .tick        (phase),
            .req_async_n (req_n[r]),
            .req_high    (req_high[r])
        );
    end

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
        logic [NUM_REQ-1:0] hits;
        clk_pair_t          pair;

        for (genvar r = 0; r < NUM_REQ; r++) begin : g_hit
            assign hits[r] = req_en[r] & req_mask[r*NUM_OUT+i] & req_high[r];
        end

        assign stop_req[i] = (|hits) | (group_stop & stoppable[i]);

        out_gate u_gate (
            .clk        (clk),
            .rst        (rst),
            .phase      (phase),
            .stop_req   (stop_req[i]),
            .float_mode (float_on_stop[i]),
            .pair       (pair)
        );

        assign clk_t[i]  = pair.t;
        assign clk_c[i]  = pair.c;
        assign clk_oe[i] = pair.oe;
    end

    // R6: an output no request touches and not stoppable keeps toggling
    assert_free_runs_R6: assert property (@(posedge clk) disable iff (rst)
        (!stoppable[0] && !(|(req_en & req_high)) && $past(!stop_req[0]) && $past(!stop_req[0], 2))
        |-> (clk_t[0] || clk_c[0]));
endmodule

// File: tb/clk_req_stopper_tb.sv
module clk_req_stopper_tb;
    localparam int N  = 8;
    localparam int NR = 2;

    logic            clk = 1'b0;
    logic            rst;
    logic [NR-1:0]   req_n;
    logic            bus_stop_n;
    logic            sw_run;
    logic [NR-1:0]   req_en;
    logic [NR*N-1:0] req_mask;
    logic [N-1:0]    stoppable;
    logic [N-1:0]    float_on_stop;
    logic [N-1:0]    clk_t, clk_c, clk_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;   // 125 MHz

    clk_req_stopper #(.NUM_OUT(N), .NUM_REQ(NR)) u_dut (
        .clk, .rst, .req_n, .bus_stop_n, .sw_run, .req_en, .req_mask,
        .stoppable, .float_on_stop, .clk_t, .clk_c, .clk_oe
    );

    // Expected stop state from the requirements
    function automatic bit exp_stop(int i);
        for (int r = 0; r < NR; r++)
            if (req_en[r] && req_mask[r*N+i] && req_n[r]) return 1'b1;
        return (!bus_stop_n || !sw_run) && stoppable[i];
    endfunction

    // Output 0 is always configured free-running: it is the phase reference
    task automatic check_all(string tag, bit stop_ok);
        for (int i = 1; i < N; i++) begin
            bit s = stop_ok && exp_stop(i);
            logic [2:0] exp = s ? {1'b0, 1'b0, !float_on_stop[i]}
                                : {clk_t[0], clk_c[0], 1'b1};
            checks++;
            if ({clk_t[i], clk_c[i], clk_oe[i]} !== exp) begin
                errors++;
                $display("FAIL %s out%0d t/c/oe actual=%b expected=%b", tag, i,
                         {clk_t[i], clk_c[i], clk_oe[i]}, exp);
            end
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    // R9 monitor: no output pulse out of step with the reference
    always @(negedge clk) begin
        if (!rst && !done) begin
            for (int i = 1; i < N; i++) begin
                if ((clk_t[i] && !clk_t[0]) || (clk_c[i] && !clk_c[0]) || (clk_t[i] && clk_c[i])) begin
                    errors++;
                    $display("FAIL R9 out%0d t/c actual=%b%b reference=%b%b", i,
                             clk_t[i], clk_c[i], clk_t[0], clk_c[0]);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst = 1; req_n = '0; bus_stop_n = 1; sw_run = 1;
        req_en = '0; req_mask = '0; stoppable = '0; float_on_stop = '0;
        wait_cyc(4);
        rst = 0;
        wait_cyc(3);
        // R1: all running after reset
        check_all("R1", 1'b0);
        checks++;
        if (clk_oe !== '1) begin
            errors++;
            $display("FAIL R1 oe actual=%b expected=%b", clk_oe, {N{1'b1}});
        end

        // R3 / R8: request 0 masks outputs 1..4, floats 3..4
        req_en = 2'b01; req_mask = 16'h001E; float_on_stop = 8'b0001_1000;
        req_n[0] = 1'b1;
        wait_cyc(12);
        check_all("R3", 1'b1);
        // R4: resume
        req_n[0] = 1'b0;
        wait_cyc(12);
        check_all("R4", 1'b0);

        // R2: one-cycle pulse is ignored
        for (int k = 0; k < 2; k++) begin
            req_n[0] = 1'b1;
            wait_cyc(1);
            req_n[0] = 1'b0;
            for (int c = 0; c < 12; c++) begin
                wait_cyc(1);
                check_all("R2", 1'b0);
            end
            wait_cyc(1);
        end

        // R5: disabled request has no effect
        req_en = 2'b00; req_mask = 16'hFEFE; req_n = 2'b11;
        wait_cyc(12);
        check_all("R5", 1'b0);
        req_n = 2'b00;

        // R6: bus stop on outputs 5..7, then release within two periods
        stoppable = 8'b1110_0000; float_on_stop = 8'b1000_0000;
        bus_stop_n = 1'b0;
        wait_cyc(12);
        check_all("R6", 1'b1);
        bus_stop_n = 1'b1;
        wait_cyc(4);
        check_all("R6", 1'b0);

        // R7: software stop
        stoppable = 8'b0110_0110;
        sw_run = 1'b0;
        wait_cyc(12);
        check_all("R7", 1'b1);
        sw_run = 1'b1;
        wait_cyc(12);
        check_all("R7", 1'b0);

        // Random mix of all controls (R3..R8)
        for (int it = 0; it < 80; it++) begin
            req_en        = NR'($urandom);
            req_mask      = (NR*N)'($urandom) & 16'hFEFE;
            stoppable     = N'($urandom) & 8'hFE;
            float_on_stop = N'($urandom);
            req_n         = NR'($urandom);
            bus_stop_n    = 1'($urandom);
            sw_run        = ($urandom % 4) != 0;
            wait_cyc(14);
            check_all("R3-mix", 1'b1);
            wait_cyc(1);
            check_all("R8-mix", 1'b1);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule